// File: doc/BRIEF.md
# Serial Port Buffer Status Flags

This block keeps the four status flags of a serial port that has one transmit holding register and one receive holding register. The shift engine sends it three strobes: transfer begins, received word copied into the receive register, and transmission finished. The bus side sends strobes for a read of the receive register, a write of the transmit register, and a write of the status register. The block turns these into the receive-full, receive-overrun, transmit-full and transmit-complete flags.

It also combines the flags with four enable bits. The result is one interrupt line, a receive DMA request and a transmit DMA request. The overrun flag warns early. It latches when a new transfer begins while the last received word is still unread, so software can react before that word is overwritten.

Top module: `sport_buf_flags`

## Requirements
- R1: On a clock edge where `xfer_start` is 1 and `rx_full` is already 1, `rx_ovr` becomes 1. A start with `rx_full` at 0 leaves `rx_ovr` unchanged.
- R2: `rx_ovr` clears only on a status write (`stat_wr`=1) with `stat_wdata[3]`=0. A status write with `stat_wdata[3]`=1 leaves it set. If a setting start happens in the same cycle as the clearing write, the flag ends up set.
- R3: `rx_full` becomes 1 on the edge after `rx_load`=1.
- R4: `rx_full` clears on the edge after `rxbuf_rd`=1. If `rx_load` is also 1 in that cycle, `rx_full` stays 1.
- R5: `tx_full` becomes 1 after `txbuf_wr`=1 and clears after `xfer_start`=1. When both happen in the same cycle, `tx_full` stays 1.
- R6: `tx_done` becomes 1 after `xfer_end`=1 while `tx_full` is 0. `xfer_end` has no effect while `tx_full` is 1. `txbuf_wr` clears `tx_done`, but a set in the same cycle wins.
- R7: `irq` is 1 exactly when (`rx_ovr` and `ovr_ie`) or (`tx_done` and `txd_ie`).
- R8: `rx_dreq` equals `rx_full` AND `rx_dma_en`. `tx_dreq` equals NOT `tx_full` AND `tx_dma_en`.
- R9: While `rst_n` is 0, all four flags are 0.
- R10: In a status write, `stat_wdata` bits 2..0 are ignored. `rx_full`, `tx_done` and `tx_full` cannot be changed by writing the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_start | input | 1 | Shift engine begins a transfer and takes the transmit word |
| rx_load | input | 1 | Shift register contents copied into the receive register |
| xfer_end | input | 1 | Last transmission has finished |
| rxbuf_rd | input | 1 | Bus read of the receive register |
| txbuf_wr | input | 1 | Bus write of the transmit register |
| stat_wr | input | 1 | Bus write of the status register |
| stat_wdata | input | 4 | Status write data; bit 3 is the overrun bit |
| ovr_ie | input | 1 | Overrun interrupt enable |
| txd_ie | input | 1 | Transmit-complete interrupt enable |
| rx_dma_en | input | 1 | Receive DMA enable |
| tx_dma_en | input | 1 | Transmit DMA enable |
| rx_ovr | output | 1 | Receive overrun warning flag |
| rx_full | output | 1 | Receive register holds unread data |
| tx_done | output | 1 | Transmit complete flag |
| tx_full | output | 1 | Transmit register holds a word |
| irq | output | 1 | Interrupt request |
| rx_dreq | output | 1 | Receive DMA request |
| tx_dreq | output | 1 | Transmit DMA request |

## Verification
The hardest cases to reach are the same-cycle collisions between a clearing bus access and a setting engine event. Examples are a status write of zero in the same edge as a start that finds unread data, or a transmit write in the same edge as the end-of-transmission strobe. The directed tasks first put the flag that the collision depends on into a known state. They then drive both strobes together on one falling edge and sample the outcome on the next falling edge.

// File: rtl/sport_buf_flags.sv
module sport_buf_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xfer_start,
  input  logic       rx_load,
  input  logic       xfer_end,
  input  logic       rxbuf_rd,
  input  logic       txbuf_wr,
  input  logic       stat_wr,
  input  logic [3:0] stat_wdata,
  input  logic       ovr_ie,
  input  logic       txd_ie,
  input  logic       rx_dma_en,
  input  logic       tx_dma_en,
  output logic       rx_ovr,
  output logic       rx_full,
  output logic       tx_done,
  output logic       tx_full,
  output logic       irq,
  output logic       rx_dreq,
  output logic       tx_dreq
);

  logic ovr_set, ovr_clr, txd_set;

  assign ovr_set = xfer_start & rx_full;
  assign ovr_clr = stat_wr & ~stat_wdata[3];
  assign txd_set = xfer_end & ~tx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ovr  <= 1'b0;
      rx_full <= 1'b0;
      tx_done <= 1'b0;
      tx_full <= 1'b0;
    end else begin
      if (ovr_set)       rx_ovr <= 1'b1;
      else if (ovr_clr)  rx_ovr <= 1'b0;

      if (rx_load)       rx_full <= 1'b1;
      else if (rxbuf_rd) rx_full <= 1'b0;

      if (txbuf_wr)        tx_full <= 1'b1;
      else if (xfer_start) tx_full <= 1'b0;

      if (txd_set)       tx_done <= 1'b1;
      else if (txbuf_wr) tx_done <= 1'b0;
    end
  end

  assign irq     = (rx_ovr & ovr_ie) | (tx_done & txd_ie);
  assign rx_dreq = rx_full & rx_dma_en;
  assign tx_dreq = ~tx_full & tx_dma_en;

endmodule

// File: rtl/sport_buf_flags_chk.sv
module sport_buf_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       xfer_start,
  input logic       rx_load,
  input logic       xfer_end,
  input logic       rxbuf_rd,
  input logic       txbuf_wr,
  input logic       stat_wr,
  input logic [3:0] stat_wdata,
  input logic       rx_ovr,
  input logic       rx_full,
  input logic       tx_done,
  input logic       tx_full
);

  p_ovr_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && rx_full) |=> rx_ovr);

  p_ovr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovr && !(stat_wr && !stat_wdata[3])) |=> rx_ovr);

  p_rxf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> rx_full);

  p_rxf_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rxbuf_rd && !rx_load) |=> !rx_full);

  p_txf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    txbuf_wr |=> tx_full);

  p_txf_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !txbuf_wr) |=> !tx_full);

  p_txd_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && !tx_full) |=> tx_done);

  p_txd_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (txbuf_wr && !(xfer_end && !tx_full)) |=> !tx_done);

  p_rxf_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !rx_load && !rxbuf_rd) |=> $stable(rx_full));

  always @(negedge clk)
    if (!rst_n)
      p_reset_zero_r9: assert ({rx_ovr, rx_full, tx_done, tx_full} == 4'b0000);

endmodule

bind sport_buf_flags sport_buf_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .rx_load(rx_load),
  .xfer_end(xfer_end), .rxbuf_rd(rxbuf_rd), .txbuf_wr(txbuf_wr),
  .stat_wr(stat_wr), .stat_wdata(stat_wdata), .rx_ovr(rx_ovr),
  .rx_full(rx_full), .tx_done(tx_done), .tx_full(tx_full)
);

// File: tb/sport_buf_flags_test.sv
module sport_buf_flags_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_start = 0, rx_load = 0, xfer_end = 0, rxbuf_rd = 0, txbuf_wr = 0, stat_wr = 0;
  logic [3:0] stat_wdata = 4'h0;
  logic ovr_ie = 0, txd_ie = 0, rx_dma_en = 0, tx_dma_en = 0;
  logic rx_ovr, rx_full, tx_done, tx_full, irq, rx_dreq, tx_dreq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sport_buf_flags uut (.*);

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic idle();
    xfer_start = 0; rx_load = 0; xfer_end = 0; rxbuf_rd = 0;
    txbuf_wr = 0; stat_wr = 0; stat_wdata = 4'h0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    tx_dma_en = 1;
    @(negedge clk);
    chk(rx_ovr, 0, "R9 rx_ovr");
    chk(rx_full, 0, "R9 rx_full");
    chk(tx_done, 0, "R9 tx_done");
    chk(tx_full, 0, "R9 tx_full");
    chk(tx_dreq, 1, "R8 tx_dreq empty");
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_rx();
    rx_dma_en = 1;
    chk(rx_dreq, 0, "R8 rx_dreq idle");
    rx_load = 1; step();
    chk(rx_full, 1, "R3 rx_full set");
    chk(rx_dreq, 1, "R8 rx_dreq");
    rxbuf_rd = 1; rx_load = 1; step();
    chk(rx_full, 1, "R4 load wins over read");
    rxbuf_rd = 1; step();
    chk(rx_full, 0, "R4 rx_full cleared");
    chk(rx_dreq, 0, "R8 rx_dreq off");
    rx_dma_en = 0;
  endtask

  task automatic t_ovr();
    xfer_start = 1; step();
    chk(rx_ovr, 0, "R1 no ovr when empty");
    rx_load = 1; step();
    xfer_start = 1; step();
    chk(rx_ovr, 1, "R1 ovr set");
    chk(irq, 0, "R7 irq masked");
    ovr_ie = 1; #1;
    chk(irq, 1, "R7 irq from ovr");
    stat_wr = 1; stat_wdata = 4'b1000; step();
    chk(rx_ovr, 1, "R2 write one ignored");
    stat_wr = 1; stat_wdata = 4'b0111; step();
    chk(rx_ovr, 0, "R2 write zero clears");
    chk(rx_full, 1, "R10 rx_full not writable");
    chk(irq, 0, "R7 irq drops");
    stat_wr = 1; stat_wdata = 4'b0000; xfer_start = 1; step();
    chk(rx_ovr, 1, "R2 set wins over clear");
    stat_wr = 1; stat_wdata = 4'b0000; step();
    rxbuf_rd = 1; step();
    ovr_ie = 0;
  endtask

  task automatic t_tx();
    txbuf_wr = 1; step();
    chk(tx_full, 1, "R5 tx_full set");
    chk(tx_dreq, 0, "R8 tx_dreq full");
    stat_wr = 1; stat_wdata = 4'b1000; step();
    chk(tx_full, 1, "R10 tx_full not writable");
    xfer_end = 1; step();
    chk(tx_done, 0, "R6 no done while full");
    xfer_start = 1; txbuf_wr = 1; step();
    chk(tx_full, 1, "R5 write wins over start");
    xfer_start = 1; step();
    chk(tx_full, 0, "R5 start clears");
    chk(tx_dreq, 1, "R8 tx_dreq empty again");
    xfer_end = 1; step();
    chk(tx_done, 1, "R6 done set");
    stat_wr = 1; stat_wdata = 4'b1000; step();
    chk(tx_done, 1, "R10 tx_done not writable");
    txd_ie = 1; #1;
    chk(irq, 1, "R7 irq from tx_done");
    txbuf_wr = 1; step();
    chk(tx_done, 0, "R6 write clears done");
    chk(irq, 0, "R7 irq clears");
    xfer_start = 1; step();
    xfer_end = 1; txbuf_wr = 1; step();
    chk(tx_done, 1, "R6 set wins over write");
    chk(tx_full, 1, "R5 write during end");
    txd_ie = 0;
  endtask

  initial begin
    idle();
    t_reset();
    t_rx();
    t_ovr();
    t_tx();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule